// File: doc/BRIEF.md
# DMA Channel Sequencer with Auto-Reload

This block is one DMA channel. Software programs a working source address, a working destination address and a transfer count, then sets a control word. Each transfer request starts either one data-unit move or a run of moves that lasts until the count is used up. The choice depends on a count-mode bit and on whether the request came from an on-chip peripheral. Each data unit is a read command on a simple memory port followed by a write command. After each unit both addresses advance by their own step and the count drops by one.

Each write to an address or count register also copies the value into a shadow reload register. When the count reaches zero, a source-reload or destination-reload enable restores the chosen address and the count from the shadows, and the channel stays enabled. A ring buffer can therefore repeat with no software help. With neither enable set, the channel switches itself off and raises an end flag.

Top module: `dma_reload_chan`

## Requirements
- R1: With the count-mode bit clear, each accepted request moves exactly one data unit and the channel then waits for the next request.
- R2: With the count-mode bit set and the request marked as coming from a peripheral (`req_periph`=1), one request moves units back to back until the count reaches zero.
- R3: A request with `req_periph`=0 moves one unit even when the count-mode bit is set.
- R4: A control write that sets enable and burst (bit 2) while the count-mode bit (bit 3) is clear leaves the channel disabled and sets the configuration-error flag (bit 12). Requests then move nothing. The next accepted control write without this combination clears the flag.
- R5: With source reload (bit 4) set, the cycle after the count reaches zero restores the source address and the count from their shadows. Enable stays set and the end flag stays clear.
- R6: With destination reload (bit 5) set, the destination address and the count are restored in the same way. With both reload bits set, both addresses are restored and the count takes its shadow value.
- R7: With neither reload bit set, the channel clears enable (bit 0) and sets the end flag (bit 1, also on `xfer_end`) once the count reaches zero.
- R8: Register map by `reg_addr`: 0 source, 1 destination, 2 count, 3 control. In the control register, source step is bits 7:6, destination step is bits 9:8 and size is bits 11:10. Control bits 31:13 read 0 and writes to them are ignored. Addresses 4 to 7 read 0.
- R9: After each unit, each address moves by its step code (0 or 3 fixed, 1 up by size, 2 down by size). The size code is 0 for 1 byte, 1 for 2 bytes and 2 or 3 for 4 bytes. The count decrements by one.
- R10: Every software write to source, destination or count also loads the matching shadow reload register.
- R11: A unit is a read at the source address and then a write of the read data at the destination address. Each command holds its address until `mem_done`, and the next unit starts only after the write's `mem_done`.
- R12: Any number of requests that arrive while a unit or run is active collapse into one pending request, which is served once the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req | input | 1 | Transfer request strobe |
| req_periph | input | 1 | Request comes from an on-chip peripheral |
| mem_valid | output | 1 | Memory command active |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Command address |
| mem_wdata | output | DW | Write data |
| mem_size | output | 2 | Data-unit size code |
| mem_rdata | input | DW | Read data, taken with `mem_done` |
| mem_done | input | 1 | Command completion |
| xfer_end | output | 1 | End flag |

## Verification
The bench targets the end of the count. A design that reloads one cycle too late, restores the wrong address, or leaves enable set without a reload would write to the wrong destinations on the next request. It also checks that a peripheral run stops exactly at zero and that a non-peripheral request moves only one unit, so a design that ignored the source type would overrun. It fires extra requests in the middle of a unit to confirm that they fold into a single pending request and are neither lost nor counted twice. Finally, it writes the forbidden burst setting to confirm that the error flag blocks all traffic, and writes all ones to the control word to catch reserved bits that can be written.

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          req,
  input  logic          req_periph,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_done,
  output logic          xfer_end
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_t;

  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_DST  = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;

  st_t           st;
  logic [AW-1:0] src, dst, src_rl, dst_rl;
  logic [CW-1:0] cnt, cnt_rl;
  logic [DW-1:0] data_q;
  logic          en, endf, burst, runm, rls, rld, err;
  logic [1:0]    sinc, dinc, size;
  logic          pend, pend_per, run_q;

  logic [AW-1:0] step;
  assign step = (size == 2'd0) ? AW'(1) : (size == 2'd1) ? AW'(2) : AW'(4);

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] m,
                                        input logic [AW-1:0] s);
    case (m)
      2'd1:    adv = a + s;
      2'd2:    adv = a - s;
      default: adv = a;
    endcase
  endfunction

  logic start, start_per, bad_cfg;
  assign start     = (st == S_IDLE) && en && (cnt != '0) && (req || pend);
  assign start_per = pend ? pend_per : req_periph;
  assign bad_cfg   = reg_wdata[0] && reg_wdata[2] && !reg_wdata[3];

  logic [31:0] ctrl_rd;
  assign ctrl_rd = {19'd0, err, size, dinc, sinc, rld, rls, runm, burst, endf, en};

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = 32'(src);
      A_DST:   reg_rdata = 32'(dst);
      A_CNT:   reg_rdata = 32'(cnt);
      A_CTRL:  reg_rdata = ctrl_rd;
      default: reg_rdata = '0;
    endcase
  end

  assign mem_valid = (st == S_RD) || (st == S_WR);
  assign mem_write = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = data_q;
  assign mem_size  = size;
  assign xfer_end  = endf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; src_rl <= '0; dst_rl <= '0;
      cnt <= '0; cnt_rl <= '0; data_q <= '0;
      en <= 1'b0; endf <= 1'b0; burst <= 1'b0; runm <= 1'b0;
      rls <= 1'b0; rld <= 1'b0; err <= 1'b0;
      sinc <= '0; dinc <= '0; size <= '0;
      pend <= 1'b0; pend_per <= 1'b0; run_q <= 1'b0;
    end else begin
      if (st != S_IDLE && en && req) begin
        pend     <= 1'b1;
        pend_per <= req_periph;
      end
      case (st)
        S_IDLE: if (start) begin
          st    <= S_RD;
          run_q <= runm && start_per;
          pend  <= 1'b0;
        end
        S_RD: if (mem_done) begin
          data_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: if (mem_done) begin
          src <= adv(src, sinc, step);
          dst <= adv(dst, dinc, step);
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1))  st <= S_FIN;
          else if (run_q)     st <= S_RD;
          else                st <= S_IDLE;
        end
        S_FIN: begin
          if (rls || rld) begin
            if (rls) src <= src_rl;
            if (rld) dst <= dst_rl;
            cnt <= cnt_rl;
          end else begin
            en   <= 1'b0;
            endf <= 1'b1;
            pend <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (reg_we) begin
        case (reg_addr)
          A_SRC: begin src <= reg_wdata[AW-1:0]; src_rl <= reg_wdata[AW-1:0]; end
          A_DST: begin dst <= reg_wdata[AW-1:0]; dst_rl <= reg_wdata[AW-1:0]; end
          A_CNT: begin cnt <= reg_wdata[CW-1:0]; cnt_rl <= reg_wdata[CW-1:0]; end
          A_CTRL: begin
            en    <= reg_wdata[0] && !bad_cfg;
            err   <= bad_cfg;
            endf  <= reg_wdata[1];
            burst <= reg_wdata[2];
            runm  <= reg_wdata[3];
            rls   <= reg_wdata[4];
            rld   <= reg_wdata[5];
            sinc  <= reg_wdata[7:6];
            dinc  <= reg_wdata[9:8];
            size  <= reg_wdata[11:10];
            if (!reg_wdata[0]) pend <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R11: a command holds until its done
  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_done && !reg_we) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  // R11: read completion is followed by the write
  a_r11_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && mem_done) |=> (mem_valid && mem_write));

  // R9: count drops by one per completed unit
  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_done && !reg_we) |=> (cnt == $past(cnt) - 1'b1));

  // R1: single mode returns to idle after one unit
  a_r1_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_write && mem_done && !run_q && cnt != CW'(1) && !reg_we) |=> !mem_valid);

  // R4: forbidden burst setting disables and flags
  a_r4_cfg_error: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CTRL && reg_wdata[0] && reg_wdata[2] && !reg_wdata[3])
      |=> (!en && err));

  // R7: no reload ends the channel
  a_r7_end_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && !rls && !rld && !reg_we) |=> (!en && xfer_end));

  // R5: source reload restores address and count, stays enabled
  a_r5_src_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && rls && !reg_we) |=> (src == $past(src_rl) && cnt == $past(cnt_rl) && en));

  // R6: destination reload restores address and count
  a_r6_dst_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && rld && !reg_we) |=> (dst == $past(dst_rl) && cnt == $past(cnt_rl) && en));

endmodule

// File: tb/dma_reload_chan_tb.sv
module dma_reload_chan_tb;
  localparam int CLK_PER = 10;
  localparam logic [31:0] KEY = 32'hA5A5_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        req = 0, req_periph = 0;
  logic        mem_valid, mem_write, mem_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        xfer_end;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PER/2) clk = ~clk;

  dma_reload_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req), .req_periph(req_periph),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata),
    .mem_done(mem_done), .xfer_end(xfer_end));

  assign mem_rdata = mem_addr ^ KEY;

  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];
  int nw = 0;
  logic [1:0] lat = 0;
  initial mem_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_done <= 0; lat <= 0;
    end else if (mem_done) begin
      mem_done <= 0;
    end else if (mem_valid) begin
      if (lat == 2'd2) begin
        mem_done <= 1; lat <= 0;
        if (mem_write && nw < 64) begin
          wa[nw] <= mem_addr; wd[nw] <= mem_wdata; nw <= nw + 1;
        end
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input bit per);
    @(negedge clk); req = 1; req_periph = per;
    @(negedge clk); req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(bit en, bit bur, bit run, bit rs, bit rdl,
                                      logic [1:0] si, logic [1:0] di, logic [1:0] sz);
    return {20'd0, sz, di, si, rdl, rs, run, bur, 1'b0, en};
  endfunction

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                       input logic [31:0] cw);
    wr(3, 0); wr(0, s); wr(1, d); wr(2, c); wr(3, cw);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3, v); chk(v == 0, "reset ctrl R8", v, 0);
    rd(2, v); chk(v == 0, "reset count R8", v, 0);
    chk(!mem_valid, "reset idle R11", 32'(mem_valid), 0);
  endtask

  task automatic t_single;
    logic [31:0] v; int b = nw;
    setup(32'h100, 32'h200, 3, ctl(1,0,0,0,0,2'd1,2'd1,2'd2));
    pulse(1); idle(40);
    chk(nw - b == 1, "R1 one unit per request", 32'(nw - b), 1);
    chk(wa[b] == 32'h200 && wd[b] == (32'h100 ^ KEY), "R11 read-then-write data", wd[b], 32'h100 ^ KEY);
    rd(2, v); chk(v == 2, "R9 count decrement", v, 2);
    rd(0, v); chk(v == 32'h104, "R9 src +4", v, 32'h104);
    pulse(1); idle(40); pulse(1); idle(40);
    chk(nw - b == 3, "R1 three requests three units", 32'(nw - b), 3);
    chk(wa[b+2] == 32'h208, "R9 dst +4 twice", wa[b+2], 32'h208);
    rd(3, v); chk(v[1:0] == 2'b10, "R7 enable off end flag on", v, {v[31:2], 2'b10});
    chk(xfer_end, "R7 xfer_end pin", 32'(xfer_end), 1);
  endtask

  task automatic t_run;
    int b = nw;
    setup(32'h1000, 32'h2000, 4, ctl(1,0,1,0,0,2'd1,2'd2,2'd1));
    pulse(1); idle(80);
    chk(nw - b == 4, "R2 run to count end", 32'(nw - b), 4);
    for (int i = 0; i < 4; i++) begin
      chk(wa[b+i] == 32'h2000 - 32'(2*i), "R9 dst -2 step", wa[b+i], 32'h2000 - 32'(2*i));
      chk(wd[b+i] == ((32'h1000 + 32'(2*i)) ^ KEY), "R9 src +2 data", wd[b+i], (32'h1000 + 32'(2*i)) ^ KEY);
    end
    chk(xfer_end, "R7 end after run", 32'(xfer_end), 1);
  endtask

  task automatic t_nonperiph;
    logic [31:0] v; int b = nw;
    setup(32'h40, 32'h80, 3, ctl(1,0,1,0,0,2'd1,2'd1,2'd2));
    pulse(0); idle(60);
    chk(nw - b == 1, "R3 non-peripheral single", 32'(nw - b), 1);
    rd(2, v); chk(v == 2, "R3 count after one", v, 2);
  endtask

  task automatic t_cfgerr;
    logic [31:0] v; int b = nw;
    setup(32'h40, 32'h80, 3, ctl(1,1,0,0,0,2'd1,2'd1,2'd2));
    rd(3, v);
    chk(v[0] == 0 && v[12] == 1, "R4 disabled with error", v, 32'h1000);
    pulse(1); idle(40);
    chk(nw - b == 0, "R4 no transfers", 32'(nw - b), 0);
    wr(3, ctl(0,0,0,0,0,0,0,0)); rd(3, v);
    chk(v[12] == 0, "R4 error cleared", v, 0);
  endtask

  task automatic t_src_reload;
    logic [31:0] v; int b = nw;
    setup(32'h300, 32'h400, 2, ctl(1,0,1,1,0,2'd1,2'd1,2'd0));
    pulse(1); idle(60);
    chk(nw - b == 2, "R5 first run", 32'(nw - b), 2);
    rd(0, v); chk(v == 32'h300, "R5 src restored", v, 32'h300);
    rd(2, v); chk(v == 2, "R5 count restored R10", v, 2);
    rd(1, v); chk(v == 32'h402, "R5 dst continues", v, 32'h402);
    rd(3, v); chk(v[1:0] == 2'b01, "R5 still enabled no end", v, 1);
    pulse(1); idle(60);
    chk(wa[b+2] == 32'h402 && wd[b+2] == (32'h300 ^ KEY), "R5 second run from shadow", wd[b+2], 32'h300 ^ KEY);
  endtask

  task automatic t_dst_reload;
    logic [31:0] v; int b = nw;
    setup(32'h700, 32'h800, 2, ctl(1,0,1,0,1,2'd1,2'd1,2'd2));
    pulse(1); idle(60);
    rd(1, v); chk(v == 32'h800, "R6 dst restored", v, 32'h800);
    rd(0, v); chk(v == 32'h708, "R6 src continues", v, 32'h708);
    pulse(1); idle(60);
    chk(nw - b == 4 && wa[b+2] == 32'h800, "R6 repeat dst", wa[b+2], 32'h800);
    setup(32'h900, 32'hA00, 3, ctl(1,0,1,1,1,2'd1,2'd2,2'd2));
    pulse(1); idle(80);
    rd(0, v); chk(v == 32'h900, "R6 both src", v, 32'h900);
    rd(1, v); chk(v == 32'hA00, "R6 both dst", v, 32'hA00);
    rd(2, v); chk(v == 3, "R6 both count once", v, 3);
  endtask

  task automatic t_reserved;
    logic [31:0] v;
    setup(0, 0, 0, 32'hFFFF_FFFF);
    rd(3, v); chk(v == 32'h0000_0FFF, "R8 reserved read zero", v, 32'h0000_0FFF);
    rd(5, v); chk(v == 0, "R8 unmapped address", v, 0);
    wr(3, 0); rd(3, v); chk(v == 0, "R8 ctrl cleared", v, 0);
  endtask

  task automatic t_pending;
    int b = nw;
    setup(32'h10, 32'h20, 5, ctl(1,0,0,0,0,2'd1,2'd1,2'd2));
    pulse(1); idle(1); pulse(1); idle(1); pulse(1);
    idle(60);
    chk(nw - b == 2, "R12 extra requests fold to one", 32'(nw - b), 2);
    chk(wa[b+1] == 32'h24, "R12 pending served in order", wa[b+1], 32'h24);
  endtask

  task automatic t_fixed;
    int b = nw;
    setup(32'h600, 32'h500, 3, ctl(1,0,1,0,0,2'd0,2'd3,2'd2));
    pulse(1); idle(80);
    chk(nw - b == 3, "R9 fixed run length", 32'(nw - b), 3);
    for (int i = 0; i < 3; i++)
      chk(wa[b+i] == 32'h500 && wd[b+i] == (32'h600 ^ KEY), "R9 fixed addresses", wa[b+i], 32'h500);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_run();
    t_nonperiph();
    t_cfgerr();
    t_src_reload();
    t_dst_reload();
    t_reserved();
    t_pending();
    t_fixed();
    summary();
  end
endmodule